// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a bus-attached watchdog. It is built on a 64-bit up-counter and a 64-bit period value. Each of them is reached as two 32-bit words through a plain register port with address, write strobe, write data and read data. Software picks the counting options and loads the period while the block is idle. It then arms the watchdog with two key writes in a fixed order. Once armed, the configuration is frozen. Software must service the timer before the counter reaches the period, using the same pair of keys in the same order. A completed service restarts the count from zero.

If the counter reaches the period while counting, or if a key arrives out of order while armed, the block trips. It raises a sticky timeout flag and drives a single-cycle reset request. Only the system reset brings it back to idle. The state machine has five states, with read-back codes IDLE 0, PREARMED 1, RUNNING 2, SERVICING 3 and TRIPPED 4. Its transitions are:
- ARM_1: IDLE to PREARMED, on the first key with enable.
- ARM_2: PREARMED to RUNNING, on the second key.
- SVC_1: RUNNING to SERVICING, on the first key.
- SVC_2: SERVICING to RUNNING, on the second key, which also clears the counter.
- BAD_KEY: PREARMED, RUNNING or SERVICING to TRIPPED, on any unexpected key.
- EXPIRE: RUNNING or SERVICING to TRIPPED, on a period match.

Top module: `keyed_wdt`

## Requirements
- R1: After reset every register reads zero except the identity word at byte 0x00, which reads the ID_VALUE parameter. The words at 0x04 and 0x08 and any other unmapped offset read zero.
- R2: In IDLE these words are writable and read back: counter low 0x10, counter high 0x14, period low 0x18 and period high 0x1C (all 32 bits each), counting mode at 0x20 (bits 7:6) and global setup at 0x24 (bits 3:0). Other bits read zero.
- R3: The control word at 0x28 takes a key in bits 31:16 and enable in bit 14. On read it returns the flag in bit 15, enable in bit 14 and the state code in bits 2:0. ARM_1 needs key 0xA5C6 with bit 14 set, and a first key without bit 14 leaves IDLE. ARM_2 needs key 0xDA7E.
- R4: The counter advances by one per clock, carrying across the two halves, only in RUNNING or SERVICING and only when the mode field is 2, setup bits 1:0 are both 1 and setup bits 3:2 equal 2. It does not advance in IDLE or PREARMED.
- R5: SVC_1 (key 0xA5C6 in RUNNING) enters SERVICING while counting continues. SVC_2 (key 0xDA7E in SERVICING) returns to RUNNING and the counter reads zero right after that write.
- R6: From PREARMED onward, writes to the counter, period, mode and setup words are ignored. The enable bit cannot be cleared.
- R7: In PREARMED, RUNNING or SERVICING, a write to 0x28 whose key is not the one expected next enters TRIPPED at that write, sets the flag and raises rst_req in the following cycle. In IDLE a key other than 0xA5C6 with enable has no effect.
- R8: When the counter equals the period while counting, the block enters TRIPPED, sets the flag and raises rst_req for exactly one cycle, one clock after the counter first shows the period value. The counter then holds that value.
- R9: TRIPPED is left only by rst_n. Key and configuration writes in TRIPPED change nothing and raise no further request.
- R10: If a period match and SVC_2 occur on the same clock, the match wins: the block trips and the counter is not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| reg_addr | input | ADDR_W (6) | Byte address of the accessed word |
| reg_we | input | 1 | Write strobe, sampled on the rising clock |
| reg_wdata | input | HALF_W (32) | Write data |
| reg_rdata | output | HALF_W (32) | Read data for reg_addr, combinational |
| rst_req | output | 1 | Single-cycle reset request on a trip |

## Verification
The EXPIRE and SVC_2 transitions can fall on the same clock: the counter holds the period value exactly when the second service key is written. The bench provokes this by arming with a short period and timing the first and second service keys so that the second lands on the match edge. It expects TRIPPED, a set flag, a reset pulse and a counter still holding the period. A second run moves the key one cycle earlier and expects a clean service, with no pulse and a counter of zero.

// File: rtl/keyed_wdt_pkg.sv
package keyed_wdt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_PRE  = 3'd1,
        ST_RUN  = 3'd2,
        ST_SVC  = 3'd3,
        ST_TRIP = 3'd4
    } wdt_state_e;

    localparam logic [15:0] KEY_FIRST  = 16'hA5C6;
    localparam logic [15:0] KEY_SECOND = 16'hDA7E;

    // word indices (byte offset / 4)
    localparam int unsigned WORD_ID     = 0;
    localparam int unsigned WORD_CNT_LO = 4;
    localparam int unsigned WORD_CNT_HI = 5;
    localparam int unsigned WORD_PER_LO = 6;
    localparam int unsigned WORD_PER_HI = 7;
    localparam int unsigned WORD_MODE   = 8;
    localparam int unsigned WORD_SETUP  = 9;
    localparam int unsigned WORD_CTRL   = 10;

    localparam logic [1:0] MODE_CONTINUOUS = 2'd2;
    localparam logic [1:0] SETUP_WATCHDOG  = 2'd2;

    localparam int unsigned KEY_LSB = 16;
    localparam int unsigned EN_BIT  = 14;
    localparam int unsigned FLAG_BIT = 15;

endpackage

// File: rtl/wdt_key_fsm.sv
module wdt_key_fsm
    import keyed_wdt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        key_wr_i,
    input  logic [15:0] key_i,
    input  logic        en_bit_i,
    input  logic        hit_i,
    output wdt_state_e  state_o,
    output logic        enable_o,
    output logic        flag_o,
    output logic        req_o,
    output logic        svc_done_o
);

    wdt_state_e state_q, state_d;
    logic       bad_key;
    logic       svc_done;
    logic       enable_q, flag_q, req_q;
    logic       entering_trip;

    // next-state logic
    always_comb begin
        state_d  = state_q;
        bad_key  = 1'b0;
        svc_done = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (key_wr_i && key_i == KEY_FIRST && en_bit_i) state_d = ST_PRE;
            end
            ST_PRE: begin
                if (key_wr_i) begin
                    if (key_i == KEY_SECOND) state_d = ST_RUN;
                    else                     bad_key = 1'b1;
                end
            end
            ST_RUN: begin
                if (key_wr_i) begin
                    if (key_i == KEY_FIRST) state_d = ST_SVC;
                    else                    bad_key = 1'b1;
                end
            end
            ST_SVC: begin
                if (key_wr_i) begin
                    if (key_i == KEY_SECOND) begin
                        state_d  = ST_RUN;
                        svc_done = 1'b1;
                    end else begin
                        bad_key = 1'b1;
                    end
                end
            end
            ST_TRIP: begin
                state_d = ST_TRIP;
            end
            default: state_d = ST_IDLE;
        endcase
        if (hit_i || bad_key) state_d = ST_TRIP;
    end

    assign entering_trip = (state_d == ST_TRIP) && (state_q != ST_TRIP);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable_q <= 1'b0;
            flag_q   <= 1'b0;
            req_q    <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && state_d == ST_PRE) enable_q <= 1'b1;
            if (entering_trip) flag_q <= 1'b1;
            req_q <= entering_trip;
        end
    end

    assign state_o    = state_q;
    assign enable_o   = enable_q;
    assign flag_o     = flag_q;
    assign req_o      = req_q;
    assign svc_done_o = svc_done;

    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_q |=> !req_q); // R8
    AST_TRIP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TRIP) |=> (state_q == ST_TRIP) && !req_q); // R9
    AST_FLAG_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> req_q); // R7
    AST_IDLE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> (state_q == ST_IDLE || state_q == ST_PRE)); // R3
    AST_ENABLE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        enable_q |=> enable_q); // R6

endmodule

// File: rtl/wdt_count_unit.sv
module wdt_count_unit #(
    parameter int unsigned HALF_W = 32,
    parameter int unsigned N_HALF = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    run_i,
    input  logic                    clr_i,
    input  logic [N_HALF-1:0]       cnt_wr_i,
    input  logic [N_HALF-1:0]       per_wr_i,
    input  logic [HALF_W-1:0]       wdata_i,
    output logic [HALF_W*N_HALF-1:0] cnt_o,
    output logic [HALF_W*N_HALF-1:0] per_o,
    output logic                    hit_o
);

    localparam int unsigned CNT_W = HALF_W * N_HALF;

    logic [CNT_W-1:0]  cnt_q;
    logic [HALF_W-1:0] per_half [N_HALF];
    logic              hit;

    assign hit = run_i && (cnt_q == per_o);

    // counter: a match freezes it, then service clear, then counting, then loads
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (hit) begin
            cnt_q <= cnt_q;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (run_i) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end else begin
            for (int h = 0; h < int'(N_HALF); h++) begin
                if (cnt_wr_i[h]) cnt_q[h*HALF_W +: HALF_W] <= wdata_i;
            end
        end
    end

    // period halves
    for (genvar h = 0; h < int'(N_HALF); h++) begin : g_per
        always_ff @(posedge clk) begin
            if (!rst_n)           per_half[h] <= '0;
            else if (per_wr_i[h]) per_half[h] <= wdata_i;
        end
        assign per_o[h*HALF_W +: HALF_W] = per_half[h];
    end

    assign cnt_o = cnt_q;
    assign hit_o = hit;

    AST_SVC_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !hit) |=> (cnt_q == '0)); // R5
    AST_HIT_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> $stable(cnt_q)); // R10
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !clr_i && !hit) |=> (cnt_q == $past(cnt_q) + CNT_W'(1))); // R4

endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
    import keyed_wdt_pkg::*;
#(
    parameter int unsigned      ADDR_W   = 6,
    parameter int unsigned      HALF_W   = 32,
    parameter logic [HALF_W-1:0] ID_VALUE = 32'h5744_0100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [HALF_W-1:0] reg_wdata,
    output logic [HALF_W-1:0] reg_rdata,
    output logic              rst_req
);

    localparam int unsigned N_HALF = 2;
    localparam int unsigned CNT_W  = HALF_W * N_HALF;
    localparam int unsigned WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0]   word;
    wdt_state_e          state;
    logic                enable, flag, svc_done, hit, run;
    logic                cfg_open, key_wr;
    logic [1:0]          mode_q;
    logic [3:0]          setup_q;
    logic [N_HALF-1:0]   cnt_wr, per_wr;
    logic [CNT_W-1:0]    cnt, per;
    logic [1:0]          unused_addr_lsb;

    assign word            = reg_addr[ADDR_W-1:2];
    assign unused_addr_lsb = reg_addr[1:0];
    assign cfg_open        = (state == ST_IDLE);
    assign key_wr          = reg_we && (word == WORD_W'(WORD_CTRL));

    assign cnt_wr[0] = reg_we && cfg_open && (word == WORD_W'(WORD_CNT_LO));
    assign cnt_wr[1] = reg_we && cfg_open && (word == WORD_W'(WORD_CNT_HI));
    assign per_wr[0] = reg_we && cfg_open && (word == WORD_W'(WORD_PER_LO));
    assign per_wr[1] = reg_we && cfg_open && (word == WORD_W'(WORD_PER_HI));

    // configuration words, writable only in IDLE
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= '0;
            setup_q <= '0;
        end else if (reg_we && cfg_open) begin
            if (word == WORD_W'(WORD_MODE))  mode_q  <= reg_wdata[7:6];
            if (word == WORD_W'(WORD_SETUP)) setup_q <= reg_wdata[3:0];
        end
    end

    assign run = (state == ST_RUN || state == ST_SVC)
              && (mode_q == MODE_CONTINUOUS)
              && (setup_q[1:0] == 2'b11)
              && (setup_q[3:2] == SETUP_WATCHDOG);

    wdt_key_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .key_wr_i   (key_wr),
        .key_i      (reg_wdata[KEY_LSB +: 16]),
        .en_bit_i   (reg_wdata[EN_BIT]),
        .hit_i      (hit),
        .state_o    (state),
        .enable_o   (enable),
        .flag_o     (flag),
        .req_o      (rst_req),
        .svc_done_o (svc_done)
    );

    wdt_count_unit #(
        .HALF_W (HALF_W),
        .N_HALF (N_HALF)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (run),
        .clr_i    (svc_done),
        .cnt_wr_i (cnt_wr),
        .per_wr_i (per_wr),
        .wdata_i  (reg_wdata),
        .cnt_o    (cnt),
        .per_o    (per),
        .hit_o    (hit)
    );

    // read mux
    always_comb begin
        reg_rdata = '0;
        case (word)
            WORD_W'(WORD_ID):     reg_rdata = ID_VALUE;
            WORD_W'(WORD_CNT_LO): reg_rdata = cnt[HALF_W-1:0];
            WORD_W'(WORD_CNT_HI): reg_rdata = cnt[CNT_W-1:HALF_W];
            WORD_W'(WORD_PER_LO): reg_rdata = per[HALF_W-1:0];
            WORD_W'(WORD_PER_HI): reg_rdata = per[CNT_W-1:HALF_W];
            WORD_W'(WORD_MODE):   reg_rdata[7:6] = mode_q;
            WORD_W'(WORD_SETUP):  reg_rdata[3:0] = setup_q;
            WORD_W'(WORD_CTRL): begin
                reg_rdata[FLAG_BIT] = flag;
                reg_rdata[EN_BIT]   = enable;
                reg_rdata[2:0]      = state;
            end
            default: reg_rdata = '0;
        endcase
    end

    AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> ($stable(mode_q) && $stable(setup_q))); // R6
    AST_PERIOD_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> $stable(per)); // R6
    AST_REQ_MEANS_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> (state == ST_TRIP && flag)); // R7

endmodule

// File: tb/keyed_wdt_tb.sv
module keyed_wdt_tb;

    localparam logic [31:0] ID_EXP = 32'h5744_0100;
    localparam logic [5:0] A_ID = 6'h00, A_EMU = 6'h04, A_GAP = 6'h08,
                           A_CLO = 6'h10, A_CHI = 6'h14, A_PLO = 6'h18,
                           A_PHI = 6'h1C, A_MODE = 6'h20, A_SETUP = 6'h24,
                           A_CTRL = 6'h28;
    localparam logic [31:0] K1_EN = 32'hA5C6_4000, K2_EN = 32'hDA7E_4000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        rst_req;

    int n_chk = 0;
    int n_fail = 0;

    keyed_wdt u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .rst_req   (rst_req)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        reg_we = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // called at a falling edge; the write lands on the next rising edge
    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_we    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic setup_run(input logic [31:0] per_lo, input logic [31:0] per_hi);
        wr(A_PLO, per_lo);
        wr(A_PHI, per_hi);
        wr(A_MODE, 32'h0000_0080);
        wr(A_SETUP, 32'h0000_000B);
    endtask

    task automatic arm();
        wr(A_CTRL, K1_EN);
        wr(A_CTRL, K2_EN);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        do_reset();
        rd(A_ID, v);   chk("R1 id word", v, ID_EXP);
        rd(A_CTRL, v); chk("R1 control after reset", v, 0);
        rd(A_CLO, v);  chk("R1 counter after reset", v, 0);
        rd(A_EMU, v);  chk("R1 word 0x04", v, 0);
        rd(A_GAP, v);  chk("R1 word 0x08", v, 0);
        chk("R1 no request after reset", rst_req, 0);
    endtask

    task automatic t_config();
        logic [31:0] v;
        do_reset();
        wr(A_PLO, 32'h0000_1234);
        wr(A_PHI, 32'hABCD_0000);
        wr(A_MODE, 32'hFFFF_FFFF);
        wr(A_SETUP, 32'hFFFF_FFFB);
        wr(A_CLO, 32'h0000_0005);
        wr(A_CHI, 32'h0000_0007);
        rd(A_PLO, v);   chk("R2 period low", v, 32'h1234);
        rd(A_PHI, v);   chk("R2 period high", v, 32'hABCD_0000);
        rd(A_MODE, v);  chk("R2 mode field", v, 32'hC0);
        rd(A_SETUP, v); chk("R2 setup field", v, 32'hB);
        repeat (4) @(negedge clk);
        rd(A_CLO, v);   chk("R4 idle counter low holds", v, 5);
        rd(A_CHI, v);   chk("R2 counter high", v, 7);
    endtask

    task automatic t_arm_lock();
        logic [31:0] v;
        do_reset();
        setup_run(32'h0000_1000, 0);
        wr(A_CTRL, 32'hA5C6_0000);
        rd(A_CTRL, v); chk("R3 first key without enable stays idle", v, 0);
        wr(A_CTRL, K1_EN);
        rd(A_CTRL, v); chk("R3 prearmed code", v, 32'h4001);
        repeat (3) @(negedge clk);
        rd(A_CLO, v);  chk("R4 no count while prearmed", v, 0);
        wr(A_PLO, 32'h77);
        wr(A_MODE, 32'h0);
        wr(A_CLO, 32'h99);
        rd(A_PLO, v);  chk("R6 period locked", v, 32'h1000);
        rd(A_MODE, v); chk("R6 mode locked", v, 32'h80);
        rd(A_CLO, v);  chk("R6 counter locked", v, 0);
        wr(A_CTRL, 32'hDA7E_0000);
        rd(A_CTRL, v); chk("R3 R6 running, enable kept", v, 32'h4002);
        repeat (3) @(negedge clk);
        rd(A_CLO, v);  chk("R4 counts one per cycle", v, 3);
        chk("R7 no request on good keys", rst_req, 0);
    endtask

    task automatic t_no_run_cfg();
        logic [31:0] v;
        do_reset();
        wr(A_PLO, 32'h3);
        arm();
        repeat (10) @(negedge clk);
        rd(A_CLO, v);  chk("R4 mode disabled, no count", v, 0);
        rd(A_CTRL, v); chk("R4 still running state", v, 32'h4002);
    endtask

    task automatic t_carry();
        logic [31:0] v;
        do_reset();
        wr(A_CLO, 32'hFFFF_FFFE);
        setup_run(32'h0000_0002, 32'h0000_0001);
        arm();
        repeat (3) @(negedge clk);
        rd(A_CLO, v); chk("R4 carry low", v, 1);
        rd(A_CHI, v); chk("R4 carry high", v, 1);
        repeat (3) @(negedge clk);
        rd(A_CTRL, v); chk("R8 64-bit match trips", v, 32'hC004);
    endtask

    task automatic t_service();
        logic [31:0] v;
        do_reset();
        setup_run(32'h0000_1000, 0);
        arm();
        repeat (5) @(negedge clk);
        wr(A_CTRL, 32'hA5C6_0000);
        rd(A_CTRL, v); chk("R5 servicing code", v, 32'h4003);
        wr(A_CTRL, 32'hDA7E_0000);
        rd(A_CLO, v);  chk("R5 counter cleared", v, 0);
        rd(A_CTRL, v); chk("R5 back to running", v, 32'h4002);
        chk("R5 no request", rst_req, 0);
    endtask

    task automatic t_badkey();
        logic [31:0] v;
        do_reset();
        wr(A_CTRL, 32'h1234_4000);
        rd(A_CTRL, v); chk("R7 idle wrong key ignored", v, 0);
        chk("R7 idle wrong key no request", rst_req, 0);
        setup_run(32'h0000_1000, 0);
        arm();
        wr(A_CTRL, 32'h0000_4000);
        chk("R7 request after bad key", rst_req, 1);
        rd(A_CTRL, v); chk("R7 tripped after bad key", v, 32'hC004);
        @(negedge clk);
        chk("R7 request one cycle", rst_req, 0);
        do_reset();
        setup_run(32'h0000_1000, 0);
        wr(A_CTRL, K1_EN);
        wr(A_CTRL, K1_EN);
        chk("R7 prearmed wrong key request", rst_req, 1);
        do_reset();
        setup_run(32'h0000_1000, 0);
        arm();
        wr(A_CTRL, K1_EN);
        wr(A_CTRL, K1_EN);
        rd(A_CTRL, v); chk("R7 servicing wrong key trips", v, 32'hC004);
    endtask

    task automatic t_timeout();
        logic [31:0] v;
        do_reset();
        setup_run(32'd10, 0);
        arm();
        for (int i = 1; i <= 12; i++) begin
            @(negedge clk);
            chk($sformatf("R8 pulse timing cycle %0d", i), rst_req, (i == 11));
        end
        rd(A_CLO, v);  chk("R8 counter holds period", v, 10);
        rd(A_CTRL, v); chk("R8 flag set", v, 32'hC004);
        wr(A_CTRL, K1_EN);
        wr(A_CTRL, K2_EN);
        wr(A_PLO, 32'h55);
        chk("R9 no second request", rst_req, 0);
        rd(A_CTRL, v); chk("R9 stays tripped", v, 32'hC004);
        rd(A_PLO, v);  chk("R9 period unchanged", v, 10);
        do_reset();
        rd(A_CTRL, v); chk("R9 reset clears trip", v, 0);
    endtask

    task automatic t_collide();
        logic [31:0] v;
        do_reset();
        setup_run(32'd10, 0);
        arm();
        repeat (9) @(negedge clk);
        wr(A_CTRL, 32'hA5C6_0000);
        wr(A_CTRL, 32'hDA7E_0000);
        chk("R10 match beats service, request", rst_req, 1);
        rd(A_CTRL, v); chk("R10 tripped", v, 32'hC004);
        rd(A_CLO, v);  chk("R10 counter not cleared", v, 10);
        do_reset();
        setup_run(32'd10, 0);
        arm();
        repeat (8) @(negedge clk);
        wr(A_CTRL, 32'hA5C6_0000);
        wr(A_CTRL, 32'hDA7E_0000);
        chk("R10 one cycle early no request", rst_req, 0);
        rd(A_CTRL, v); chk("R10 early service running", v, 32'h4002);
        rd(A_CLO, v);  chk("R10 early service clears", v, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_config();
        t_arm_lock();
        t_no_run_cfg();
        t_carry();
        t_service();
        t_badkey();
        t_timeout();
        t_collide();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule